// File: doc/BRIEF.md
# Ping-Pong DMA Channel Controller

This block controls one channel of a four-way transfer switch. Data flows from a writer port into one of two buffers (even and odd). From there it flows out to a reader port. While the writer fills one buffer, the reader can drain the other. The controller decides which buffer each side uses, counts the lines, and enforces the ownership rules between the two sides. Line addresses and the buffer memory sit outside the block. The adapters are driven through level "go" outputs, per-line strobes and a one-cycle abort pulse.

Software steers the channel with single control-word writes. It can start, stop, abort, approve a held buffer, drop a held buffer, or push one buffer to the reader without a writer. With approval turned on, each buffer is flagged after its second line is written. The reader is then kept away from that buffer until the host approves or drops it. A status word reports the following:
- the two line counts,
- an encoded channel state,
- the pending-approval flag of each buffer,
- the write-done flag of each buffer.

Top module: `ppdma_channel`

## Requirements
- R1: A control write carries the opcode in bits 3:0 and the approval-enable bit in bit 4. A write with any of bits 31:5 set is ignored, and opcodes 9 to 15 are ignored.
- R2: `status` is laid out as follows, and it reads all zero after reset:
  - bits 31:22 hold the even-buffer line count;
  - bits 21:12 hold the odd-buffer line count;
  - bits 11:4 hold the state (0 idle, 1 running, 2 stopping, 3 sending);
  - bit 0 is pending-even, bit 1 is pending-odd, bit 2 is write-done-even and bit 3 is write-done-odd.
- R3: Opcode 1, accepted only while idle, does the following:
  - clears all flags and counts;
  - latches the approval-enable bit;
  - makes the writer fill even first and then alternate;
  - sets a buffer's write-done flag once `cfg_wr_last`+1 lines have been written into it.
- R4: A buffer's write-done flag and line count clear when the writer claims that buffer, before its first line.
- R5: The writer claims a buffer only after its previous contents have been read out or dropped. Until then `wr_go` stays low.
- R6: The reader drains every completed buffer that is not pending, reading as many lines as were written. When both buffers are ready, the older one is read first.
- R7: With approval enabled, a buffer's pending flag sets once its second line is written. The reader never starts on a pending buffer. A one-line buffer never becomes pending.
- R8: Opcode 3 approves the even buffer and opcode 4 the odd buffer. Opcode 5 drops the even buffer and opcode 6 the odd buffer. Each acts only on a pending buffer and clears its flag. A dropped buffer is never read, and the channel keeps running. These opcodes have no effect on a buffer that is not pending.
- R9: Opcode 2 moves a running channel to stopping. In that state no new buffer is claimed. The channel returns to idle once the current write is finished, no read is active and no buffer holds data.
- R10: Opcode 7 sends buffer 0 and opcode 8 sends buffer 1; both are accepted only while idle. The reader reads `cfg_send_last`+1 lines from that buffer in the sending state, and the channel then returns to idle.
- R11: Opcode 0 returns the channel to idle at once from any state. It clears flags and counts. If an adapter was active, it raises `abort` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | CTRL_W | Control word (opcode, approval enable, reserved) |
| cfg_wr_last | input | IDX_W | Index of the last line the writer puts in each buffer |
| cfg_send_last | input | IDX_W | Index of the last line read on a host send |
| wr_line | input | 1 | Writer has written one line (valid while `wr_go`) |
| rd_line | input | 1 | Reader has read one line (valid while `rd_go`) |
| wr_go | output | 1 | Writer adapter may write into `wr_buf` |
| wr_buf | output | 1 | Buffer the writer targets (0 even, 1 odd) |
| rd_go | output | 1 | Reader adapter may read from `rd_buf` |
| rd_buf | output | 1 | Buffer the reader drains |
| abort | output | 1 | One-cycle pulse telling the adapters to abandon work |
| status | output | STAT_W | Line counts, state and flags |

## Verification
The bench builds the block with its defaults:
- `IDX_W` = 9, which gives the 32-bit status layout with 10-bit counts;
- `REG_STATUS` = 0, so status reflects the state of the current cycle.

Buffer lengths come from the config ports rather than from parameters. Short buffers of four lines, and single-line buffers, therefore reach the following within a few cycles:
- approval on the second line, including the case where that line is also the last;
- stalls when both buffers are full;
- drops while a buffer is still being written;
- the refill that clears a write-done flag.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
   localparam int NBUF    = 2;
   localparam int OP_W    = 4;
   localparam int STFLD_W = 8;
   localparam int FLAG_W  = 4;

   localparam logic [OP_W-1:0] OP_ABORT = 4'd0;
   localparam logic [OP_W-1:0] OP_START = 4'd1;
   localparam logic [OP_W-1:0] OP_STOP  = 4'd2;
   localparam logic [OP_W-1:0] OP_APPR0 = 4'd3;
   localparam logic [OP_W-1:0] OP_APPR1 = 4'd4;
   localparam logic [OP_W-1:0] OP_DROP0 = 4'd5;
   localparam logic [OP_W-1:0] OP_DROP1 = 4'd6;
   localparam logic [OP_W-1:0] OP_SEND0 = 4'd7;
   localparam logic [OP_W-1:0] OP_SEND1 = 4'd8;

   typedef enum logic [1:0] {
      CH_IDLE     = 2'd0,
      CH_RUN      = 2'd1,
      CH_STOPPING = 2'd2,
      CH_SENDING  = 2'd3
   } ch_state_e;

   typedef struct packed {
      logic            abort;
      logic            start;
      logic            stop;
      logic [NBUF-1:0] approve;
      logic [NBUF-1:0] drop;
      logic [NBUF-1:0] send;
      logic            appr_req;
   } cmd_t;
endpackage

// File: rtl/ppdma_cmd_decode.sv
module ppdma_cmd_decode
   import ppdma_pkg::*;
#(
   parameter int CTRL_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output cmd_t              cmd
);
   localparam int RSV_LO = OP_W + 1;

   logic            legal;
   logic [OP_W-1:0] op;

   assign legal = ctrl_we && (ctrl_wdata[CTRL_W-1:RSV_LO] == '0);
   assign op    = ctrl_wdata[OP_W-1:0];

   always_comb begin
      cmd = '0;
      if (legal) begin
         cmd.appr_req = ctrl_wdata[OP_W];
         case (op)
            OP_ABORT: cmd.abort      = 1'b1;
            OP_START: cmd.start      = 1'b1;
            OP_STOP:  cmd.stop       = 1'b1;
            OP_APPR0: cmd.approve[0] = 1'b1;
            OP_APPR1: cmd.approve[1] = 1'b1;
            OP_DROP0: cmd.drop[0]    = 1'b1;
            OP_DROP1: cmd.drop[1]    = 1'b1;
            OP_SEND0: cmd.send[0]    = 1'b1;
            OP_SEND1: cmd.send[1]    = 1'b1;
            default:  cmd            = '0;
         endcase
      end
   end

   // R1: at most one action per control write
   assert_single_action_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd.abort, cmd.start, cmd.stop, cmd.approve, cmd.drop, cmd.send}));

   // R1: reserved bits set means nothing happens
   assert_reserved_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wdata[CTRL_W-1:RSV_LO] != '0) |-> (cmd == '0));
endmodule

// File: rtl/ppdma_buf.sv
module ppdma_buf #(
   parameter int IDX_W = 9,
   parameter int CNT_W = IDX_W + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             claim,
   input  logic             line,
   input  logic [IDX_W-1:0] last_idx,
   input  logic             appr_en,
   input  logic             approve,
   input  logic             drop,
   input  logic             read_done,
   output logic [CNT_W-1:0] cnt,
   output logic             pend,
   output logic             wdone,
   output logic             full,
   output logic             writing
);
   localparam logic [CNT_W-1:0] SECOND = CNT_W'(1);

   logic dropped;
   logic final_line;
   logic drop_hit;
   logic appr_hit;

   assign final_line = writing && line && (cnt == CNT_W'(last_idx));
   assign drop_hit   = drop && pend;
   assign appr_hit   = approve && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; pend <= 1'b0; wdone <= 1'b0;
         full <= 1'b0; writing <= 1'b0; dropped <= 1'b0;
      end else if (clear) begin
         cnt <= '0; pend <= 1'b0; wdone <= 1'b0;
         full <= 1'b0; writing <= 1'b0; dropped <= 1'b0;
      end else if (claim) begin
         cnt     <= '0;
         wdone   <= 1'b0;
         pend    <= 1'b0;
         dropped <= 1'b0;
         writing <= 1'b1;
      end else begin
         if (writing && line) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == SECOND && appr_en && !dropped)
               pend <= 1'b1;
            if (final_line) begin
               writing <= 1'b0;
               wdone   <= 1'b1;
               full    <= !(dropped || drop_hit);
            end
         end
         if (appr_hit)
            pend <= 1'b0;
         if (drop_hit) begin
            pend <= 1'b0;
            if (writing && !final_line)
               dropped <= 1'b1;
            if (full)
               full <= 1'b0;
         end
         if (read_done)
            full <= 1'b0;
      end
   end

   // R7: approval hold only after the second line
   assert_pend_needs_two_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> (cnt >= CNT_W'(2)));

   // R4: claiming clears done flag and count
   assert_claim_clears_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && !clear) |=> (!wdone && cnt == '0 && writing));

   // R5: a buffer holding data is never written
   assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && writing));
endmodule

// File: rtl/ppdma_sched.sv
module ppdma_sched
   import ppdma_pkg::*;
#(
   parameter int IDX_W = 9,
   parameter int CNT_W = IDX_W + 1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      c_abort,
   input  logic                      c_start,
   input  logic                      c_stop,
   input  logic [NBUF-1:0]           c_send,
   input  logic                      c_appr_req,
   input  logic                      wr_line,
   input  logic                      rd_line,
   input  logic [IDX_W-1:0]          send_last,
   input  logic [NBUF-1:0]           full,
   input  logic [NBUF-1:0]           pend,
   input  logic [NBUF-1:0]           writing,
   input  logic [NBUF-1:0][CNT_W-1:0] buf_cnt,
   output logic [NBUF-1:0]           claim,
   output logic [NBUF-1:0]           line_to,
   output logic [NBUF-1:0]           read_done,
   output logic                      clear_all,
   output logic                      appr_en,
   output logic                      wr_go,
   output logic                      wr_buf,
   output logic                      rd_go,
   output logic                      rd_buf,
   output logic                      abort,
   output ch_state_e                 state
);
   logic             wr_ptr, rd_ptr, rd_act, pick, rd_start, rd_last;
   logic [NBUF-1:0]  ready;
   logic [CNT_W-1:0] rd_cnt, rd_target;

   assign ready     = full & ~pend;
   assign pick      = ready[rd_ptr] ? rd_ptr : ~rd_ptr;
   assign rd_start  = (state == CH_RUN || state == CH_STOPPING) && !rd_act &&
                      (|ready) && !c_abort;
   assign rd_last   = rd_act && rd_line && (rd_cnt + CNT_W'(1) == rd_target);
   assign clear_all = c_abort || (c_start && state == CH_IDLE);
   assign wr_go     = |writing;
   assign rd_go     = rd_act;

   always_comb begin
      claim = '0;
      if (state == CH_RUN && !c_abort && !c_stop && !(|writing) && !full[wr_ptr])
         claim[wr_ptr] = 1'b1;
   end

   for (genvar b = 0; b < NBUF; b++) begin : g_route
      assign line_to[b]   = wr_line && (wr_buf == 1'(b));
      assign read_done[b] = rd_last && (rd_buf == 1'(b)) && (state != CH_SENDING);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CH_IDLE; wr_ptr <= 1'b0; wr_buf <= 1'b0; rd_ptr <= 1'b0;
         rd_act <= 1'b0; rd_buf <= 1'b0; rd_cnt <= '0; rd_target <= '0;
         abort <= 1'b0; appr_en <= 1'b0;
      end else begin
         abort <= c_abort && ((|writing) || rd_act);
         if (c_abort) begin
            state  <= CH_IDLE;
            rd_act <= 1'b0;
            wr_ptr <= 1'b0;
            rd_ptr <= 1'b0;
         end else begin
            if (|claim) begin
               wr_buf <= wr_ptr;
               wr_ptr <= ~wr_ptr;
            end
            if (rd_start) begin
               rd_act    <= 1'b1;
               rd_buf    <= pick;
               rd_cnt    <= '0;
               rd_target <= buf_cnt[pick];
            end else if (rd_act && rd_line) begin
               if (rd_last) begin
                  rd_act <= 1'b0;
                  if (state != CH_SENDING)
                     rd_ptr <= ~rd_buf;
               end else begin
                  rd_cnt <= rd_cnt + CNT_W'(1);
               end
            end
            case (state)
               CH_IDLE: begin
                  if (c_start) begin
                     state   <= CH_RUN;
                     appr_en <= c_appr_req;
                     wr_ptr  <= 1'b0;
                     rd_ptr  <= 1'b0;
                  end else if (|c_send) begin
                     state     <= CH_SENDING;
                     rd_act    <= 1'b1;
                     rd_buf    <= c_send[1];
                     rd_cnt    <= '0;
                     rd_target <= CNT_W'(send_last) + CNT_W'(1);
                  end
               end
               CH_RUN:
                  if (c_stop) state <= CH_STOPPING;
               CH_STOPPING:
                  if (!(|writing) && !rd_act && full == '0) state <= CH_IDLE;
               CH_SENDING:
                  if (rd_last) state <= CH_IDLE;
               default: state <= CH_IDLE;
            endcase
         end
      end
   end

   // R7: reader never sits on a pending buffer
   assert_reader_skips_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && state != CH_SENDING) |-> !pend[rd_buf]);

   // R5: the buffer under write holds no unread data
   assert_writer_on_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |-> !full[wr_buf]);

   // R9: an idle channel has no writer activity
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CH_IDLE) |-> !wr_go);

   // R11: abort is a single-cycle pulse
   assert_abort_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !abort);

   // R10: sending state always has the reader engaged
   assert_send_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CH_SENDING) |-> rd_go);
endmodule

// File: rtl/ppdma_channel.sv
module ppdma_channel
   import ppdma_pkg::*;
#(
   parameter int IDX_W      = 9,
   parameter int CTRL_W     = 32,
   parameter bit REG_STATUS = 1'b0,
   localparam int CNT_W     = IDX_W + 1,
   localparam int STAT_W    = 2 * CNT_W + STFLD_W + FLAG_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic [IDX_W-1:0]  cfg_wr_last,
   input  logic [IDX_W-1:0]  cfg_send_last,
   input  logic              wr_line,
   input  logic              rd_line,
   output logic              wr_go,
   output logic              wr_buf,
   output logic              rd_go,
   output logic              rd_buf,
   output logic              abort,
   output logic [STAT_W-1:0] status
);
   if (IDX_W < 2 || IDX_W > 14) begin : g_bad_idx
      $error("ppdma_channel: IDX_W must lie in 2..14");
   end
   if (CTRL_W < OP_W + 2) begin : g_bad_ctrl
      $error("ppdma_channel: CTRL_W too narrow for opcode, approval bit and reserved field");
   end

   cmd_t                      cmd;
   ch_state_e                 state;
   logic [NBUF-1:0]           claim, line_to, read_done, full, pend, wdone, writing;
   logic [NBUF-1:0][CNT_W-1:0] buf_cnt;
   logic                      clear_all, appr_en;
   logic [STAT_W-1:0]         stat_c;

   ppdma_cmd_decode #(.CTRL_W(CTRL_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .cmd(cmd)
   );

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      ppdma_buf #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_buf (
         .clk(clk), .rst_n(rst_n), .clear(clear_all), .claim(claim[b]),
         .line(line_to[b]), .last_idx(cfg_wr_last), .appr_en(appr_en),
         .approve(cmd.approve[b]), .drop(cmd.drop[b]), .read_done(read_done[b]),
         .cnt(buf_cnt[b]), .pend(pend[b]), .wdone(wdone[b]), .full(full[b]),
         .writing(writing[b])
      );
   end

   ppdma_sched #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_sched (
      .clk(clk), .rst_n(rst_n),
      .c_abort(cmd.abort), .c_start(cmd.start), .c_stop(cmd.stop),
      .c_send(cmd.send), .c_appr_req(cmd.appr_req),
      .wr_line(wr_line), .rd_line(rd_line), .send_last(cfg_send_last),
      .full(full), .pend(pend), .writing(writing), .buf_cnt(buf_cnt),
      .claim(claim), .line_to(line_to), .read_done(read_done),
      .clear_all(clear_all), .appr_en(appr_en),
      .wr_go(wr_go), .wr_buf(wr_buf), .rd_go(rd_go), .rd_buf(rd_buf),
      .abort(abort), .state(state)
   );

   assign stat_c = {buf_cnt[0], buf_cnt[1], STFLD_W'(state), wdone[1], wdone[0], pend[1], pend[0]};

   if (REG_STATUS) begin : g_stat_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status <= '0;
         else        status <= stat_c;
      end
   end else begin : g_stat_comb
      assign status = stat_c;
   end

   // R5: only one buffer is claimed at a time
   assert_one_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim));

   // R11: after an abort command nothing is left running
   assert_abort_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.abort |=> (!wr_go && !rd_go && pend == '0));
endmodule

// File: tb/ppdma_channel_tb.sv
module ppdma_channel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic [IDX_W-1:0] cfg_wr_last = 9'd3;
   logic [IDX_W-1:0] cfg_send_last = 9'd0;
   logic        wr_line = 1'b0;
   logic        rd_line = 1'b0;
   logic        wr_go, wr_buf, rd_go, rd_buf, abort;
   logic [31:0] status;

   int nchk = 0;
   int nfail = 0;
   int wr_budget = 0;
   int claims = 0;
   bit rd_en = 1'b0;
   bit wr_go_q = 1'b0;
   bit finished = 1'b0;

   int    exp_q[$];
   string tag_q[$];
   int    burst_n = 0;
   int    burst_buf = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ppdma_channel u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .cfg_wr_last(cfg_wr_last), .cfg_send_last(cfg_send_last),
      .wr_line(wr_line), .rd_line(rd_line), .wr_go(wr_go), .wr_buf(wr_buf),
      .rd_go(rd_go), .rd_buf(rd_buf), .abort(abort), .status(status)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] stat(int ce, int co, int st, logic [3:0] fl);
      return {10'(ce), 10'(co), 8'(st), fl};
   endfunction

   // writer model: one line per cycle while budget remains
   always @(negedge clk) begin
      if (wr_go && !wr_go_q) claims++;
      wr_go_q = wr_go;
      if (wr_budget > 0 && wr_go) begin
         wr_line = 1'b1;
         wr_budget--;
      end else begin
         wr_line = 1'b0;
      end
      rd_line = rd_en && rd_go;
   end

   // scoreboard monitor: compare each finished read burst
   always @(posedge clk) begin
      if (rd_go && rd_line) begin
         burst_n++;
         burst_buf = int'(rd_buf);
      end else if (!rd_go && burst_n > 0) begin
         nchk++;
         if (exp_q.size() == 0) begin
            nfail++;
            $display("FAIL R6 unexpected burst: actual buf%0d/%0d lines expected none",
                     burst_buf, burst_n);
         end else begin
            automatic int    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (e != burst_buf * 1000 + burst_n) begin
               nfail++;
               $display("FAIL %s burst: actual buf%0d/%0d lines expected buf%0d/%0d lines",
                        t, burst_buf, burst_n, e / 1000, e % 1000);
            end
         end
         burst_n = 0;
      end
   end

   task automatic expect_burst(int b, int n, string tag);
      exp_q.push_back(b * 1000 + n);
      tag_q.push_back(tag);
   endtask

   task automatic ctrl(logic [31:0] d);
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = d;
      @(negedge clk);
      ctrl_we = 1'b0;
      ctrl_wdata = '0;
   endtask

   task automatic write_lines(int n);
      wr_budget = n;
      while (wr_budget > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle_wait();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (status[11:4] == 8'd0 && !rd_go && burst_n == 0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic sb_empty(string tag);
      check(tag, exp_q.size(), 0, "scoreboard drained");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL R0 watchdog: actual hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R2", status, 32'h0, "status after reset");
      check("R2", {wr_go, rd_go, abort}, 3'b000, "outputs after reset");

      // R1: reserved bit set, unknown opcode -> nothing happens
      ctrl(32'h0010_0001);
      repeat (3) @(negedge clk);
      check("R1", {status, 1'(wr_go)}, {32'h0, 1'b0}, "start with reserved bit");
      ctrl(32'h0000_000C);
      repeat (3) @(negedge clk);
      check("R1", {status, 1'(wr_go)}, {32'h0, 1'b0}, "opcode 12");

      // R3/R6: continuous run, four buffers alternate
      cfg_wr_last = 9'd3;
      rd_en = 1'b1;
      claims = 0;
      expect_burst(0, 4, "R6"); expect_burst(1, 4, "R6");
      expect_burst(0, 4, "R6"); expect_burst(1, 4, "R6");
      wr_budget = 1000000;
      ctrl(32'h1);
      while (claims < 4) @(negedge clk);
      ctrl(32'h2);
      idle_wait();
      wr_budget = 0;
      check("R3", status, stat(4, 4, 0, 4'b1100), "status after four buffers");
      sb_empty("R6");

      // R5: reader off, writer stalls after two buffers
      rd_en = 1'b0;
      wr_budget = 1000000;
      ctrl(32'h1);
      repeat (30) @(negedge clk);
      check("R5", wr_go, 1'b0, "writer stalled");
      check("R3", status, stat(4, 4, 1, 4'b1100), "both buffers written");
      ctrl(32'h2);
      check("R9", status[11:4], 8'd2, "stopping state");
      expect_burst(0, 4, "R6"); expect_burst(1, 4, "R6");
      rd_en = 1'b1;
      idle_wait();
      wr_budget = 0;
      check("R9", status[11:4], 8'd0, "idle after drain");
      sb_empty("R6");

      // R7/R8: approval on both buffers
      wr_budget = 1000000;
      ctrl(32'h11);
      repeat (30) @(negedge clk);
      check("R7", status, stat(4, 4, 1, 4'b1111), "both pending");
      check("R7", rd_go, 1'b0, "reader held off");
      expect_burst(1, 4, "R8");
      ctrl(32'h4);
      repeat (15) @(negedge clk);
      check("R8", status, stat(4, 4, 1, 4'b1101), "odd approved and read");
      sb_empty("R8");
      ctrl(32'h4);
      repeat (2) @(negedge clk);
      check("R8", status, stat(4, 4, 1, 4'b1101), "approve non-pending ignored");
      ctrl(32'h2);
      ctrl(32'h5);
      idle_wait();
      wr_budget = 0;
      check("R8", status, stat(4, 4, 0, 4'b1100), "even dropped, idle");
      sb_empty("R8");
      ctrl(32'h3);
      repeat (2) @(negedge clk);
      check("R8", status, stat(4, 4, 0, 4'b1100), "approve in idle ignored");

      // R7/R8: drop while the buffer is still being written
      ctrl(32'h11);
      repeat (2) @(negedge clk);
      check("R3", status, stat(0, 0, 1, 4'b0000), "start clears flags");
      write_lines(2);
      check("R7", status, stat(2, 0, 1, 4'b0001), "pending after second line");
      ctrl(32'h5);
      check("R8", status, stat(2, 0, 1, 4'b0000), "drop clears pending");
      write_lines(2);
      repeat (2) @(negedge clk);
      check("R8", {status, 1'(wr_go), 1'(wr_buf), 1'(rd_go)},
            {stat(4, 0, 1, 4'b0100), 1'b1, 1'b1, 1'b0}, "dropped buffer skipped");
      ctrl(32'h2);
      write_lines(4);
      check("R7", status, stat(4, 4, 2, 4'b1110), "odd pending in stopping");
      expect_burst(1, 4, "R7");
      ctrl(32'h4);
      idle_wait();
      check("R9", status[11:4], 8'd0, "idle after approval");
      sb_empty("R7");

      // R4: refill clears write-done
      ctrl(32'h1);
      expect_burst(0, 4, "R4"); expect_burst(1, 4, "R4"); expect_burst(0, 4, "R4");
      write_lines(4);
      write_lines(4);
      repeat (3) @(negedge clk);
      check("R4", status, stat(0, 4, 1, 4'b1000), "even reclaimed");
      ctrl(32'h2);
      write_lines(4);
      idle_wait();
      sb_empty("R4");

      // R7: single-line buffer never pends
      cfg_wr_last = 9'd0;
      ctrl(32'h11);
      repeat (2) @(negedge clk);
      ctrl(32'h2);
      expect_burst(0, 1, "R7");
      write_lines(1);
      idle_wait();
      check("R7", status, stat(1, 0, 0, 4'b0100), "one line, no pending");
      sb_empty("R7");

      // R10: host send of buffer 1
      cfg_send_last = 9'd2;
      expect_burst(1, 3, "R10");
      rd_en = 1'b0;
      ctrl(32'h8);
      check("R10", {status[11:4], 1'(rd_go), 1'(rd_buf)}, {8'd3, 1'b1, 1'b1}, "sending");
      rd_en = 1'b1;
      idle_wait();
      check("R10", status[11:4], 8'd0, "idle after send");
      sb_empty("R10");

      // R11: abort in the middle of a write
      cfg_wr_last = 9'd3;
      rd_en = 1'b0;
      ctrl(32'h1);
      write_lines(1);
      check("R11", wr_go, 1'b1, "writer active");
      ctrl(32'h0);
      check("R11", abort, 1'b1, "abort pulse");
      check("R11", {status, 1'(wr_go), 1'(rd_go)}, {32'h0, 1'b0, 1'b0}, "state cleared");
      @(negedge clk);
      check("R11", abort, 1'b0, "abort one cycle");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule